// File: doc/BRIEF.md
# Serial Lock Qualifier with Output Mute

This block runs in the recovered bit-clock domain of a serial receiver. It decides whether the clock recovery loop is truly locked to the incoming stream. It declares lock only while three things hold together. First, bit transitions keep arriving. Second, the external phase-lock indication is high. Third, the loop is not sitting on a harmonic.

The harmonic test relies on one fact about double-clocked lock. If every bit is sampled twice, a single-bit alternation (a high bit between two lows, or a low bit between two highs) can never appear in the retimed stream. The block therefore requires such an alternation at least once in each harmonic window. The window is timed by a slow tick that is already synchronised into the bit-clock domain.

While the block is not locked, or while the carrier indication is low, the serial data output is frozen at its last value and a mute flag is raised. Short gaps in the input stream are ridden through without dropping lock.

Top module: `rx_lock_guard`

## Requirements
- R1: `lock_o` rises at the first clock edge that samples `pll_lock_i` high while the data-present and non-harmonic conditions already hold. It is low whenever any of the three conditions was false at the previous edge.
- R2: A transition is a sampled bit that differs from the bit sampled one edge earlier. Data presence is lost at the edge that completes `ACT_WIN` consecutive edges without a transition. `lock_o` falls at the next edge.
- R3: The harmonic window spans `HARM_TICKS` pulses of `sys_tick_i`. At the tick that closes a window, the non-harmonic condition is set if a 101 or 010 triplet was sampled in that window, and cleared otherwise. A doubled-bit stream (110011...) therefore never gives lock.
- R4: While `muted_o` is high, `sdo_o` holds its last value, whatever `sdi_i` does.
- R5: `carrier_i` low raises `muted_o` at the next edge and leaves `lock_o` unchanged.
- R6: Synchronous active-high `rst` gives `lock_o`=0, `muted_o`=1, `sdo_o`=0, and clears every window count.
- R7: A gap of fewer than `ACT_WIN` transition-free edges, inside otherwise valid alternating data, keeps `lock_o` high and the output unmuted.
- R8: While unmuted, `sdo_o` after each edge equals the `sdi_i` value sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst | input | 1 | Synchronous reset, active high |
| sdi_i | input | 1 | Retimed serial data bit |
| pll_lock_i | input | 1 | Phase-lock indication from the analog loop |
| carrier_i | input | 1 | Carrier present indication |
| sys_tick_i | input | 1 | One-cycle tick that paces the harmonic window |
| lock_o | output | 1 | Qualified lock flag |
| muted_o | output | 1 | High while the data output is frozen |
| sdo_o | output | 1 | Gated serial data output |

## Verification
All three outputs come from registers. `lock_o` and `muted_o` react one edge after their inputs are sampled. The data-loss path adds one more edge, so `lock_o` falls `ACT_WIN`+1 edges after the last transition. Harmonic status changes only at the closing tick of a window. The bench drives inputs and samples outputs on the falling clock edge, and counts edges from the rising edge that samples each change. Table vectors run long enough for the slowest window to settle. Directed tests probe the exact edges before and after each boundary: the gap limit, lock entry and the carrier-driven mute.

// File: rtl/rx_lock_pkg.sv
package rx_lock_pkg;

    // Conditions that together qualify lock
    typedef struct packed {
        logic data_ok;
        logic harm_ok;
        logic pll_ok;
    } lock_cond_t;

    // Fill level of the bit history after reset
    typedef enum logic [1:0] {
        HIST_EMPTY = 2'd0,
        HIST_ONE   = 2'd1,
        HIST_FULL  = 2'd2
    } hist_fill_e;

    // True for 101 or 010: the middle bit differs from both neighbours
    function automatic logic alt_triplet(input logic [2:0] h);
        return (h[0] ^ h[1]) & (h[1] ^ h[2]);
    endfunction

    function automatic logic all_met(input lock_cond_t c);
        return c.data_ok & c.harm_ok & c.pll_ok;
    endfunction

    // Counter width that never collapses to zero
    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rx_bit_history.sv
module rx_bit_history
    import rx_lock_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sdi_i,
    output logic edge_o,
    output logic alt_o
);

    logic       d1_q;
    logic       d2_q;
    hist_fill_e fill_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            d1_q   <= 1'b0;
            d2_q   <= 1'b0;
            fill_q <= HIST_EMPTY;
        end else begin
            d1_q <= sdi_i;
            d2_q <= d1_q;
            case (fill_q)
                HIST_EMPTY: fill_q <= HIST_ONE;
                HIST_ONE:   fill_q <= HIST_FULL;
                default:    fill_q <= HIST_FULL;
            endcase
        end
    end

    always_comb begin
        edge_o = (fill_q != HIST_EMPTY) && (sdi_i != d1_q);
        alt_o  = (fill_q == HIST_FULL) && alt_triplet({d2_q, d1_q, sdi_i});
    end

    // An alternation always ends with a transition
    AST_ALT_HAS_EDGE: assert property (@(posedge clk) disable iff (rst)
        alt_o |-> edge_o); // R3

endmodule

// File: rtl/rx_activity_mon.sv
module rx_activity_mon
    import rx_lock_pkg::*;
#(
    parameter int ACT_WIN = 270
) (
    input  logic clk,
    input  logic rst,
    input  logic edge_i,
    output logic data_ok_o
);

    localparam int QW = cnt_width(ACT_WIN + 1);
    typedef logic [QW-1:0] quiet_t;
    localparam quiet_t Q_LAST = quiet_t'(ACT_WIN - 1);
    localparam quiet_t Q_FULL = quiet_t'(ACT_WIN);

    quiet_t quiet_q;
    logic   ok_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            quiet_q <= '0;
            ok_q    <= 1'b0;
        end else if (edge_i) begin
            quiet_q <= '0;
            ok_q    <= 1'b1;
        end else begin
            if (quiet_q != Q_FULL) quiet_q <= quiet_q + 1'b1;
            if (quiet_q == Q_LAST) ok_q    <= 1'b0;
        end
    end

    assign data_ok_o = ok_q;

    // Presence drops only once a full silent window has elapsed
    AST_DROP_AFTER_WINDOW: assert property (@(posedge clk) disable iff (rst)
        $fell(ok_q) |-> quiet_q == Q_FULL); // R2
    AST_RISE_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        $rose(ok_q) |-> quiet_q == '0); // R7

endmodule

// File: rtl/rx_harm_mon.sv
module rx_harm_mon
    import rx_lock_pkg::*;
#(
    parameter int HARM_TICKS = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic alt_i,
    output logic harm_ok_o
);

    localparam int TW = cnt_width(HARM_TICKS);
    typedef logic [TW-1:0] tcnt_t;
    localparam tcnt_t T_LAST = tcnt_t'(HARM_TICKS - 1);

    tcnt_t tcnt_q;
    logic  seen_q;
    logic  ok_q;
    logic  seen_now;

    assign seen_now = seen_q | alt_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            tcnt_q <= '0;
            seen_q <= 1'b0;
            ok_q   <= 1'b0;
        end else if (tick_i && (tcnt_q == T_LAST)) begin
            ok_q   <= seen_now;
            seen_q <= 1'b0;
            tcnt_q <= '0;
        end else begin
            seen_q <= seen_now;
            if (tick_i) tcnt_q <= tcnt_q + 1'b1;
        end
    end

    assign harm_ok_o = ok_q;

    // The verdict moves only on a window-closing tick
    AST_HARM_RISE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(ok_q) |-> $past(tick_i)); // R3
    AST_HARM_FALL_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        $fell(ok_q) |-> $past(tick_i)); // R3

endmodule

// File: rtl/rx_lock_gate.sv
module rx_lock_gate
    import rx_lock_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  lock_cond_t cond_i,
    input  logic       carrier_i,
    input  logic       sdi_i,
    output logic       lock_o,
    output logic       muted_o,
    output logic       sdo_o
);

    logic lock_q;
    logic pass_q;
    logic sdo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= 1'b0;
            pass_q <= 1'b0;
            sdo_q  <= 1'b0;
        end else begin
            lock_q <= all_met(cond_i);
            pass_q <= all_met(cond_i) & carrier_i;
            if (pass_q) sdo_q <= sdi_i;
        end
    end

    assign lock_o  = lock_q;
    assign muted_o = ~pass_q;
    assign sdo_o   = sdo_q;

    AST_LOCK_NEEDS_PLL: assert property (@(posedge clk) disable iff (rst)
        lock_q |-> $past(cond_i.pll_ok)); // R1
    AST_LOCK_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
        lock_q |-> $past(cond_i.data_ok)); // R2
    AST_LOCK_NEEDS_HARM: assert property (@(posedge clk) disable iff (rst)
        lock_q |-> $past(cond_i.harm_ok)); // R3
    AST_MUTE_FREEZES: assert property (@(posedge clk) disable iff (rst)
        muted_o |=> $stable(sdo_q)); // R4
    AST_PASS_IMPLIES_LOCK: assert property (@(posedge clk) disable iff (rst)
        !muted_o |-> lock_q); // R4
    AST_CARRIER_MUTES: assert property (@(posedge clk) disable iff (rst)
        !carrier_i |=> muted_o); // R5
    AST_PASS_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (!muted_o && !rst) |=> sdo_q == $past(sdi_i)); // R8

endmodule

// File: rtl/rx_lock_guard.sv
module rx_lock_guard
    import rx_lock_pkg::*;
#(
    parameter int ACT_WIN    = 270,
    parameter int HARM_TICKS = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic sdi_i,
    input  logic pll_lock_i,
    input  logic carrier_i,
    input  logic sys_tick_i,
    output logic lock_o,
    output logic muted_o,
    output logic sdo_o
);

    logic       edge_w;
    logic       alt_w;
    logic       data_ok_w;
    logic       harm_ok_w;
    lock_cond_t cond_w;

    rx_bit_history u_hist (
        .clk    (clk),
        .rst    (rst),
        .sdi_i  (sdi_i),
        .edge_o (edge_w),
        .alt_o  (alt_w)
    );

    rx_activity_mon #(.ACT_WIN(ACT_WIN)) u_act (
        .clk       (clk),
        .rst       (rst),
        .edge_i    (edge_w),
        .data_ok_o (data_ok_w)
    );

    rx_harm_mon #(.HARM_TICKS(HARM_TICKS)) u_harm (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (sys_tick_i),
        .alt_i     (alt_w),
        .harm_ok_o (harm_ok_w)
    );

    always_comb begin
        cond_w.data_ok = data_ok_w;
        cond_w.harm_ok = harm_ok_w;
        cond_w.pll_ok  = pll_lock_i;
    end

    rx_lock_gate u_gate (
        .clk       (clk),
        .rst       (rst),
        .cond_i    (cond_w),
        .carrier_i (carrier_i),
        .sdi_i     (sdi_i),
        .lock_o    (lock_o),
        .muted_o   (muted_o),
        .sdo_o     (sdo_o)
    );

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (!lock_o && muted_o && !sdo_o)); // R6

endmodule

// File: tb/rx_lock_guard_bench.sv
`timescale 1ns/1ps
module rx_lock_guard_bench;

    localparam int ACT_WIN    = 20;
    localparam int HARM_TICKS = 4;
    localparam int TICK_EVERY = 10;
    localparam int SETTLE     = 150;
    localparam int NVEC       = 7;

    // {mode[1:0], pll, carrier, exp_lock, exp_muted}; mode 0 alternating, 1 doubled, 2 held
    localparam logic [5:0] VEC [NVEC] = '{
        6'b00_1_1_1_0,   // R1 all conditions met
        6'b00_0_1_0_1,   // R1 phase lock missing
        6'b01_1_1_0_1,   // R3 doubled-bit harmonic stream
        6'b00_1_1_1_0,   // R1 relock
        6'b10_1_1_0_1,   // R2 no transitions
        6'b00_1_0_1_1,   // R5 carrier lost, lock kept
        6'b00_1_1_1_0    // R8 back to passthrough
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sdi = 1'b0;
    logic pll = 1'b0;
    logic cd  = 1'b0;
    logic tick = 1'b0;
    logic lock_w, muted_w, sdo_w;

    int   n_chk = 0;
    int   n_fail = 0;
    int   ph = 0;
    logic [1:0] mode = 2'd0;
    logic prev_b = 1'b0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    rx_lock_guard #(.ACT_WIN(ACT_WIN), .HARM_TICKS(HARM_TICKS)) u_rx_lock_guard (
        .clk        (clk),
        .rst        (rst),
        .sdi_i      (sdi),
        .pll_lock_i (pll),
        .carrier_i  (cd),
        .sys_tick_i (tick),
        .lock_o     (lock_w),
        .muted_o    (muted_w),
        .sdo_o      (sdo_w)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Wait for a falling edge, remember the bit just sampled, drive the next one
    task automatic step();
        @(negedge clk);
        prev_b = sdi;
        ph++;
        case (mode)
            2'd0:    sdi = ~sdi;
            2'd1:    if (ph % 2 == 0) sdi = ~sdi;
            default: sdi = sdi;
        endcase
        tick = (ph % TICK_EVERY == 0);
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic s;
        logic c;
        repeat (3) @(negedge clk);
        // R6 reset state
        chk(lock_w == 1'b0, "R6", "lock in reset", lock_w, 0);
        chk(muted_w == 1'b1, "R6", "mute in reset", muted_w, 1);
        chk(sdo_w == 1'b0, "R6", "sdo in reset", sdo_w, 0);
        rst = 1'b0;

        // Table walk
        for (int v = 0; v < NVEC; v++) begin
            mode = VEC[v][5:4];
            pll  = VEC[v][3];
            cd   = VEC[v][2];
            steps(SETTLE);
            chk(lock_w == VEC[v][1], "R1 table", $sformatf("vec %0d lock", v), lock_w, VEC[v][1]);
            chk(muted_w == VEC[v][0], "R1 table", $sformatf("vec %0d mute", v), muted_w, VEC[v][0]);
            if (!VEC[v][0]) begin
                step();
                chk(sdo_w == prev_b, "R8", $sformatf("vec %0d passthrough", v), sdo_w, prev_b);
            end else begin
                s = sdo_w;
                steps(8);
                chk(sdo_w == s, "R4", $sformatf("vec %0d frozen", v), sdo_w, s);
            end
        end

        // R7 gap just under the window: lock and passthrough held
        mode = 2'd2;
        for (int i = 1; i <= ACT_WIN - 1; i++) begin
            step();
            chk(lock_w == 1'b1 && muted_w == 1'b0, "R7", $sformatf("gap edge %0d", i), lock_w, 1);
        end
        mode = 2'd0;
        for (int i = 0; i < 6; i++) begin
            step();
            chk(lock_w == 1'b1, "R7", "after gap lock", lock_w, 1);
            chk(sdo_w == prev_b, "R8", "after gap data", sdo_w, prev_b);
        end
        steps(SETTLE);

        // R2 gap of a full window: lock falls exactly one edge after presence is lost
        mode = 2'd2;
        c = sdi;
        for (int i = 1; i <= ACT_WIN + 2; i++) begin
            step();
            if (i == ACT_WIN + 1)
                chk(lock_w == 1'b1, "R2", "lock before drop edge", lock_w, 1);
            if (i == ACT_WIN + 2) begin
                chk(lock_w == 1'b0, "R2", "lock after drop edge", lock_w, 0);
                chk(muted_w == 1'b1, "R2", "mute after drop edge", muted_w, 1);
            end
        end

        // R4 freeze while muted with toggling input
        pll = 1'b0;
        mode = 2'd0;
        for (int i = 0; i < 10; i++) begin
            step();
            chk(sdo_w == c, "R4", "held while muted", sdo_w, c);
        end
        steps(SETTLE);

        // R1 lock entry edge
        pll = 1'b1;
        chk(lock_w == 1'b0, "R1", "lock before sampling pll", lock_w, 0);
        step();
        chk(lock_w == 1'b1, "R1", "lock one edge after pll", lock_w, 1);
        chk(muted_w == 1'b0, "R1", "unmuted one edge after pll", muted_w, 0);

        // R5 carrier mute edge, lock unaffected
        steps(3);
        cd = 1'b0;
        step();
        chk(muted_w == 1'b1, "R5", "mute after carrier drop", muted_w, 1);
        chk(lock_w == 1'b1, "R5", "lock kept on carrier drop", lock_w, 1);
        s = sdo_w;
        steps(5);
        chk(sdo_w == s, "R4", "frozen on carrier loss", sdo_w, s);
        cd = 1'b1;
        step();
        chk(muted_w == 1'b0, "R5", "unmute on carrier return", muted_w, 0);

        // R6 reset while locked
        @(negedge clk);
        rst = 1'b1;
        steps(2);
        chk(lock_w == 1'b0 && muted_w == 1'b1 && sdo_w == 1'b0, "R6", "reset while locked",
            {lock_w, muted_w, sdo_w}, 3'b010);
        rst = 1'b0;
        steps(5);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule